// File: doc/BRIEF.md
# Masked Configuration Space Register File

This block holds the configuration bytes of a single endpoint function. Software reaches it through a byte-addressed port that moves 1, 2 or 4 bytes per access. A mode input sets how large the space is: 256 bytes for a conventional function, or 4096 bytes when express mode is on. Read data is gathered little-endian from consecutive bytes and is returned one cycle after the request. On a write, only the bits that the byte's write mask permits are changed.

Each byte's write mask is a fixed function of its offset, in line with the standard header rules. The read-only header bytes take parameter values at reset and keep them afterwards. A separate combinational port supports image-restore validation. It compares one incoming byte against the stored byte and reports a conflict in any bit that is protected by the compare mask and that software cannot write.

Top module: `cfgspace_regfile`

## Requirements
- R1: The space size is 256 bytes when `express_en` is 0 and 4096 bytes when it is 1. A byte at or past the end is never written, and it reads as zero. Storage beyond 256 bytes keeps its value while legacy mode is selected.
- R2: A write sets each addressed byte to (old & ~mask) | (new & mask), where mask is that byte's write mask. Byte k of the access takes `acc_wdata[8k+7:8k]`.
- R3: A multi-byte write that runs past the end of the space updates only the bytes that lie inside it.
- R4: Read data is little-endian, with byte k of the access on `rd_data[8k+7:8k]`. Lanes above the access width read as zero, and so do lanes that fall past the end of the space.
- R5: The bytes at offsets 0x0C and 0x3C have a write mask of 0xFF.
- R6: The byte at offset 0x04 has a write mask of 0x07 (bit 0 enables I/O space, bit 1 enables memory space, bit 2 enables bus mastering). The byte at offset 0x05 is read-only.
- R7: Every byte from offset 0x40 to the end of the current space has a write mask of 0xFF.
- R8: All other bytes below 0x40 have a write mask of zero. They reset to parameter values: bytes 0x00-0x03 = `ID_WORD`, 0x08-0x0B = `CLASS_REV`, 0x0E = `HDR_KIND`, 0x2C-0x2F = `SUBSYS_WORD`, 0x3D = `IRQ_PIN_VAL`, all little-endian, and 0 everywhere else. Writes never change these bytes.
- R9: `acc_width` is legal only at 1, 2 or 4. An access with any other value writes nothing and returns no read data. It pulses `acc_err` high for exactly one cycle, in the cycle after the request.
- R10: `chk_reject` is 1 when `chk_addr` is inside the current space and (`chk_image_byte` ^ stored byte) & `chk_cmask` & ~write mask is nonzero. Otherwise it is 0. The output is combinational.
- R11: A legal read raises `rd_valid` for one cycle, in the cycle after the request, with `rd_data` valid. A write never raises `rd_valid`. After reset, `rd_valid` and `acc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| express_en | input | 1 | 1 selects the 4096-byte space, 0 selects the 256-byte space |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_width | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_addr | input | 12 | Byte offset of the first byte |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, little-endian |
| acc_err | output | 1 | Illegal width seen in the previous cycle |
| chk_addr | input | 12 | Byte offset for the restore check |
| chk_image_byte | input | 8 | Incoming image byte |
| chk_cmask | input | 8 | Compare mask for that byte |
| chk_reject | output | 1 | Image byte conflicts with a protected bit |

## Verification
The assertions assume that `acc_valid` is a single-cycle request. They also assume that `express_en` does not change between a read request and the cycle its data returns, because the clipping check uses the mode in effect when the request was made. The stimulus changes inputs only at the falling clock edge. It issues each access for exactly one cycle and changes the mode only between accesses, so both assumptions always hold. The sweeps cover every legacy offset at every width, express-mode offsets near and at the end of the space, and all illegal width codes.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  localparam int HDR_BYTES = 64;
  localparam int LANES     = 4;

  // write mask of one byte, a pure function of its offset
  function automatic logic [7:0] byte_wmask(input int unsigned off);
    if (off >= HDR_BYTES) return 8'hFF;
    case (off)
      32'h04:         return 8'h07;
      32'h0C, 32'h3C: return 8'hFF;
      default:        return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] merge_byte(input logic [7:0] old_b,
                                            input logic [7:0] new_b,
                                            input logic [7:0] m);
    return (old_b & ~m) | (new_b & m);
  endfunction

  // number of bytes for a width code, zero when illegal
  function automatic logic [2:0] width_bytes(input logic [2:0] w);
    case (w)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd4:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/cfgspace_decode.sv
module cfgspace_decode #(
  parameter int AW        = 12,
  parameter int LEG_BYTES = 256,
  parameter int EXT_BYTES = 4096
) (
  input  logic                       express_en,
  input  logic [AW-1:0]              addr,
  input  logic [2:0]                 width,
  output logic                       legal,
  output logic [cfgspace_pkg::LANES-1:0] lane_en,
  output logic                       last_byte
);
  localparam int SW = AW + 1;

  logic [SW-1:0] space;
  logic [2:0]    nbytes;

  assign space     = express_en ? SW'(EXT_BYTES) : SW'(LEG_BYTES);
  assign nbytes    = cfgspace_pkg::width_bytes(width);
  assign legal     = (nbytes != 3'd0);
  assign last_byte = ({1'b0, addr} == (space - SW'(1)));

  for (genvar k = 0; k < cfgspace_pkg::LANES; k++) begin : g_lane
    assign lane_en[k] = (3'(k) < nbytes) && (({1'b0, addr} + SW'(k)) < space);
  end
endmodule

// File: rtl/cfgspace_store.sv
module cfgspace_store #(
  parameter int           AW       = 12,
  parameter int           DEPTH    = 4096,
  parameter logic [511:0] HDR_INIT = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  addr,
  input  logic [cfgspace_pkg::LANES-1:0] lane_en,
  input  logic [31:0]                    wdata,
  output logic [31:0]                    lane_rd,
  input  logic [AW-1:0]                  chk_addr,
  output logic [7:0]                     chk_value
);
  import cfgspace_pkg::*;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] lane_addr [LANES];

  function automatic logic [7:0] reset_byte(input int i);
    int j;
    j = i % HDR_BYTES;
    if (i >= HDR_BYTES) return 8'h00;
    return HDR_INIT[8*j +: 8] & ~byte_wmask(i);
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k]     = addr + AW'(k);
    assign lane_rd[8*k +: 8] = lane_en[k] ? mem[lane_addr[k]] : 8'h00;
  end

  assign chk_value = mem[chk_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reset_byte(i);
    end else if (wr_en) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_en[k])
          mem[lane_addr[k]] <= merge_byte(mem[lane_addr[k]], wdata[8*k +: 8],
                                           byte_wmask(int'(lane_addr[k])));
      end
    end
  end

  // identification byte is read-only
  assert_ro_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(mem[0]));
  // command byte upper bits are read-only
  assert_cmd_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(mem[4][7:3]));
endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile #(
  parameter int          LEG_BYTES   = 256,
  parameter int          EXT_BYTES   = 4096,
  parameter logic [31:0] ID_WORD     = 32'h5A1F_0C37,
  parameter logic [31:0] CLASS_REV   = 32'h0880_0003,
  parameter logic [31:0] SUBSYS_WORD = 32'h0001_5A1F,
  parameter logic [7:0]  HDR_KIND    = 8'h80,
  parameter logic [7:0]  IRQ_PIN_VAL = 8'h01,
  localparam int         AW          = $clog2(EXT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          express_en,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [2:0]    acc_width,
  input  logic [AW-1:0] acc_addr,
  input  logic [31:0]   acc_wdata,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          acc_err,
  input  logic [AW-1:0] chk_addr,
  input  logic [7:0]    chk_image_byte,
  input  logic [7:0]    chk_cmask,
  output logic          chk_reject
);
  import cfgspace_pkg::*;

  function automatic logic [511:0] build_hdr();
    logic [511:0] h;
    h = '0;
    h[31:0]        = ID_WORD;
    h[95:64]       = CLASS_REV;
    h[8*14 +: 8]   = HDR_KIND;
    h[8*44 +: 32]  = SUBSYS_WORD;
    h[8*61 +: 8]   = IRQ_PIN_VAL;
    return h;
  endfunction

  localparam logic [511:0] HDR_INIT = build_hdr();

  logic             dec_legal;
  logic [LANES-1:0] lane_en;
  logic             last_rd;
  logic [31:0]      lane_rd;
  logic [7:0]       chk_value;
  logic             rd_req;
  logic             wr_req;
  logic             chk_in_space;

  cfgspace_decode #(.AW(AW), .LEG_BYTES(LEG_BYTES), .EXT_BYTES(EXT_BYTES)) u_decode (
    .express_en(express_en), .addr(acc_addr), .width(acc_width),
    .legal(dec_legal), .lane_en(lane_en), .last_byte(last_rd)
  );

  assign rd_req = acc_valid && !acc_write && dec_legal;
  assign wr_req = acc_valid &&  acc_write && dec_legal;

  cfgspace_store #(.AW(AW), .DEPTH(EXT_BYTES), .HDR_INIT(HDR_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req), .addr(acc_addr), .lane_en(lane_en),
    .wdata(acc_wdata), .lane_rd(lane_rd), .chk_addr(chk_addr), .chk_value(chk_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      acc_err  <= acc_valid && !dec_legal;
      if (rd_req) rd_data <= lane_rd;
    end
  end

  assign chk_in_space = express_en ? ({1'b0, chk_addr} < (AW+1)'(EXT_BYTES))
                                   : ({1'b0, chk_addr} < (AW+1)'(LEG_BYTES));
  assign chk_reject = chk_in_space &&
    (|((chk_image_byte ^ chk_value) & chk_cmask & ~byte_wmask(int'(chk_addr))));

  assert_rd_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_bad_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !dec_legal) |=> (acc_err && !rd_valid));
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !rd_valid);
  assert_clip_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(last_rd)) |-> (rd_data[31:8] == 24'h0));
endmodule

// File: tb/cfgspace_regfile_bench.sv
module cfgspace_regfile_bench;
  localparam logic [31:0] B_ID   = 32'h5A1F_0C37;
  localparam logic [31:0] B_CLS  = 32'h0880_0003;
  localparam logic [31:0] B_SUB  = 32'h0001_5A1F;
  localparam logic [7:0]  B_HDR  = 8'h80;
  localparam logic [7:0]  B_PIN  = 8'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic express_en = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_width = 3'd1;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic rd_valid, acc_err, chk_reject;
  logic [31:0] rd_data;
  logic [11:0] chk_addr = '0;
  logic [7:0] chk_image_byte = '0, chk_cmask = '0;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [4096];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  cfgspace_regfile u_cfgspace_regfile (
    .clk(clk), .rst_n(rst_n), .express_en(express_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_width(acc_width), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
    .chk_addr(chk_addr), .chk_image_byte(chk_image_byte), .chk_cmask(chk_cmask),
    .chk_reject(chk_reject)
  );

  function automatic logic [7:0] mask_of(input int a);
    if (a == 4) return 8'h07;
    if (a == 12 || a == 60 || a >= 64) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic int space_now();
    return express_en ? 4096 : 256;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    for (int k = 0; k < 4; k++) begin
      model[k]      = B_ID[8*k +: 8];
      model[8 + k]  = B_CLS[8*k +: 8];
      model[44 + k] = B_SUB[8*k +: 8];
    end
    model[14] = B_HDR;
    model[61] = B_PIN;
  endtask

  task automatic access(input logic wr, input int a, input int w, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a[11:0];
    acc_width = w[2:0]; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_write(input int a, input int w, input logic [31:0] d);
    if (w == 1 || w == 2 || w == 4)
      for (int k = 0; k < w; k++)
        if (a + k < space_now())
          model[a+k] = (model[a+k] & ~mask_of(a+k)) | (d[8*k +: 8] & mask_of(a+k));
    access(1'b1, a, w, d);
  endtask

  task automatic read_check(input string req, input int a, input int w);
    logic [31:0] exp;
    exp = '0;
    for (int k = 0; k < w; k++)
      if (a + k < space_now()) exp[8*k +: 8] = model[a+k];
    access(1'b0, a, w, 32'h0);
    check(req, {31'h0, rd_valid}, 32'h1);
    check(req, rd_data, exp);
  endtask

  task automatic chk_probe(input string req, input int a, input logic [7:0] img,
                           input logic [7:0] cm);
    logic exp;
    @(negedge clk);
    chk_addr = a[11:0]; chk_image_byte = img; chk_cmask = cm;
    #1;
    exp = (a < space_now()) && (|((img ^ model[a]) & cm & ~mask_of(a)));
    check(req, {31'h0, chk_reject}, {31'h0, exp});
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R11 reset rd_valid", {31'h0, rd_valid}, 32'h0);
    check("R11 reset acc_err", {31'h0, acc_err}, 32'h0);
    rst_n = 1'b1;

    // R8 header reset values
    for (int a = 0; a < 64; a += 4) read_check("R8 reset header", a, 4);

    // R2 R5 R6 R7 R8: every legacy byte, set-all then clear-all
    for (int a = 0; a < 256; a++) begin
      do_write(a, 1, 32'hFF);
      read_check("R2 R5 R6 R7 R8 byte set", a, 1);
      do_write(a, 1, 32'h00);
      read_check("R2 R5 R6 R7 R8 byte clear", a, 1);
    end

    // R4 R3: width 2 and 4 at every legacy offset, including end clipping
    for (int a = 0; a < 256; a++) begin
      do_write(a, 2, {16'h0, a[7:0], ~a[7:0]});
      read_check("R4 R3 halfword", a, 2);
      do_write(a, 4, {a[7:0] ^ 8'h3C, 8'hC3, ~a[7:0], a[7:0]});
      read_check("R4 R3 word", a, 4);
      read_check("R4 byte of word", a, 1);
    end

    // R1: legacy access past the end dropped, storage kept for express mode
    express_en = 1'b1;
    do_write(12'h100, 4, 32'hDEAD_BEEF);
    express_en = 1'b0;
    do_write(12'h100, 4, 32'h1111_2222);
    read_check("R1 legacy past end reads zero", 12'h100, 4);
    read_check("R1 legacy last byte", 12'h0FF, 4);
    express_en = 1'b1;
    read_check("R1 express keeps upper storage", 12'h100, 4);

    // R1 R3 R4 R7: express end of space
    for (int a = 12'hFF8; a < 4096; a++) begin
      do_write(a, 4, {a[7:0], 8'h5A, ~a[7:0], 8'hA5});
      read_check("R3 R7 express tail word", a, 4);
      read_check("R4 express tail half", a, 2);
    end
    for (int a = 256; a < 4096; a += 97) begin
      do_write(a, 4, step(a));
      read_check("R1 R7 express sweep", a, 4);
    end

    // R9: illegal width codes
    for (int w = 0; w < 8; w++) begin
      if (w != 1 && w != 2 && w != 4) begin
        do_write(12'h080, w, 32'hFFFF_FFFF);
        check("R9 err flag", {31'h0, acc_err}, 32'h1);
        check("R9 no rd_valid", {31'h0, rd_valid}, 32'h0);
        @(negedge clk);
        check("R9 err one cycle", {31'h0, acc_err}, 32'h0);
        read_check("R9 data unchanged", 12'h080, 4);
        access(1'b0, 12'h080, w, 32'h0);
        check("R9 illegal read no data", {31'h0, rd_valid}, 32'h0);
      end
    end

    // R11: write does not raise rd_valid
    do_write(12'h0C, 1, 32'h42);
    check("R11 write no rd_valid", {31'h0, rd_valid}, 32'h0);

    // R10: restore validation probes
    chk_probe("R10 ro byte differs", 0, ~model[0], 8'hFF);
    chk_probe("R10 ro byte no cmask", 0, ~model[0], 8'h00);
    chk_probe("R10 ro byte equal", 1, model[1], 8'hFF);
    chk_probe("R10 writable differs", 12, ~model[12], 8'hFF);
    chk_probe("R10 cmd writable bit", 4, model[4] ^ 8'h01, 8'hFF);
    chk_probe("R10 cmd ro bit", 4, model[4] ^ 8'h08, 8'hFF);
    chk_probe("R10 cmd ro bit outside cmask", 4, model[4] ^ 8'h08, 8'hF7);
    chk_probe("R10 ext writable", 12'h800, ~model[12'h800], 8'hFF);
    express_en = 1'b0;
    chk_probe("R10 outside legacy space", 12'h800, ~model[12'h800], 8'hFF);
    express_en = 1'b1;

    // mixed traffic
    for (int n = 0; n < 1500; n++) begin
      int a, w;
      lfsr = step(lfsr);
      a = int'(lfsr[11:0]);
      w = (lfsr[13:12] == 2'd0) ? 1 : (lfsr[13:12] == 2'd1) ? 2 : 4;
      express_en = lfsr[20] | lfsr[21];
      if (lfsr[14]) do_write(a, w, step(lfsr));
      else read_check("R2 R4 mixed traffic", a, w);
    end
    express_en = 1'b1;
    for (int a = 0; a < 4096; a += 61) read_check("R2 final scan", a, 4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule